// File: doc/BRIEF.md
# Distributed Time-of-Day Clock Unit

This unit keeps a node's copy of a system-wide time of day. The visible time is a 64-bit unsigned fixed-point count: the upper quadlet holds whole seconds and the lower quadlet holds a binary fraction of a second. Below those 64 bits sits a further hidden fraction. Together they form a wide accumulator. On each oscillator tick the accumulator grows by a software-programmed tick period. The oscillator tick must arrive at least once per microsecond for the clock to meet its resolution. Software slows or speeds the clock by reprogramming that period.

Software reaches the unit through a quadlet-wide register port. It can set and read the seconds and fraction words, and it programs the period as a staged upper word and a committing lower word. The two-step commit swaps the whole increment on a single edge, so a half-written period is never added. A single-cycle pulse from the bus clock-strobe freezes the current visible time into a pair of read-only snapshot words. Synchronization software later compares that snapshot against a reference.

The register port has no handshake. A write is taken on every clock edge where the write enable is high. Read data is a combinational function of the address and the stored state, so no back-pressure exists on either path. Tick and strobe are plain single-cycle control pulses.

Top module: `sync_clock_unit`

## Requirements
- R1: After reset, all eight register addresses read as zero.
- R2: The unit keeps a 96-bit accumulator made of seconds [95:64], visible fraction [63:32] and hidden fraction [31:0]. On a cycle with `tick_en` high and no clock-value write, the accumulator gains {32'h0, active period word, period low word}. Address 0 reads seconds and address 1 reads the visible fraction. Without a tick or a write, the time does not change.
- R3: Accumulator overflow wraps modulo 2^96 with no other effect.
- R4: A write to address 2 only stages the period's middle word. Reading address 2 returns the staged value. The increment in use is unchanged until a write to address 3.
- R5: A write to address 3 loads the period low word and moves the staged middle word into the active increment on the same edge. A tick in that same cycle still adds the previous increment. Address 3 reads the period low word.
- R6: A write to address 0 (seconds) or address 1 (visible fraction) replaces that word and zeroes the hidden fraction. The other visible word is kept. Such a write takes priority over a tick in the same cycle, and that tick is lost.
- R7: When `strobe` is high, the visible time held before that edge (pre-tick, pre-write) is captured. Its seconds are readable at address 4 and its fraction at address 5. Snapshot words change only on a strobe, and writes to them are ignored.
- R8: Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oscillator tick, one cycle per advance |
| strobe | input | 1 | Bus clock-strobe pulse, one cycle |
| csr_addr | input | 3 | Register address (map in R2, R4, R5, R7, R8) |
| csr_we | input | 1 | Write enable for `csr_wdata` |
| csr_wdata | input | 32 | Write data quadlet |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |

## Verification
The bench places a register write in the same cycle as a tick or a strobe. Four cases are covered: a value write against a tick, a period-low commit against a tick, a strobe against a tick, and a strobe against a value write. Each outcome is compared with a 96-bit arithmetic model that applies the priority and pre-edge rules. Before reading back, the bench ticks again at a fraction-only period. A carry that should or should not reach the visible fraction then shows whether the hidden bits were cleared.

// File: rtl/sync_clk_pkg.sv
package sync_clk_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_SEC      = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FRAC     = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PER_MID  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PER_LO   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SNAP_SEC = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SNAP_FRC = 3'd5;
endpackage

// File: rtl/clk_period_regs.sv
module clk_period_regs #(
  parameter int QUAD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stage,
  input  logic              wr_lo,
  input  logic [QUAD_W-1:0] wdata,
  output logic [QUAD_W-1:0] stage_q,
  output logic [QUAD_W-1:0] act_mid_q,
  output logic [QUAD_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      act_mid_q <= '0;
      lo_q      <= '0;
    end else begin
      if (wr_stage) stage_q <= wdata;
      if (wr_lo) begin
        lo_q      <= wdata;
        act_mid_q <= stage_q;
      end
    end
  end
endmodule

// File: rtl/clk_accum.sv
module clk_accum #(
  parameter int QUAD_W   = 32,
  parameter int HIDDEN_W = 32,
  localparam int ACC_W   = 2*QUAD_W + HIDDEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_sec,
  input  logic              wr_frac,
  input  logic [QUAD_W-1:0] wdata,
  input  logic [QUAD_W-1:0] inc_mid,
  input  logic [QUAD_W-1:0] inc_lo,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] lo_aligned;
  logic [ACC_W-1:0] inc_full;

  // place the low period word at the top of the hidden fraction
  generate
    if (HIDDEN_W >= QUAD_W) begin : g_lo_wide
      assign lo_aligned = ACC_W'(inc_lo) << (HIDDEN_W - QUAD_W);
    end else begin : g_lo_narrow
      assign lo_aligned = ACC_W'(inc_lo >> (QUAD_W - HIDDEN_W));
    end
  endgenerate

  assign inc_full = (ACC_W'(inc_mid) << HIDDEN_W) | lo_aligned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (wr_sec) begin
      acc_q <= {wdata, acc_q[ACC_W-QUAD_W-1 -: QUAD_W], {HIDDEN_W{1'b0}}};
    end else if (wr_frac) begin
      acc_q <= {acc_q[ACC_W-1 -: QUAD_W], wdata, {HIDDEN_W{1'b0}}};
    end else if (tick) begin
      acc_q <= acc_q + inc_full;
    end
  end
endmodule

// File: rtl/clk_strobe_latch.sv
module clk_strobe_latch #(
  parameter int QUAD_W  = 32,
  parameter int N_WORDS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe,
  input  logic [N_WORDS*QUAD_W-1:0] snap_in,
  output logic [N_WORDS*QUAD_W-1:0] snap_q
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) snap_q[w*QUAD_W +: QUAD_W] <= '0;
      else if (strobe) snap_q[w*QUAD_W +: QUAD_W] <= snap_in[w*QUAD_W +: QUAD_W];
    end
  end
endmodule

// File: rtl/sync_clock_unit.sv
module sync_clock_unit
  import sync_clk_pkg::*;
#(
  parameter int QUAD_W   = 32,
  parameter int HIDDEN_W = 32,
  localparam int ACC_W   = 2*QUAD_W + HIDDEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [QUAD_W-1:0] csr_wdata,
  output logic [QUAD_W-1:0] csr_rdata
);
  logic [ACC_W-1:0]    acc_q;
  logic [QUAD_W-1:0]   stage_q, act_mid_q, lo_q;
  logic [2*QUAD_W-1:0] snap_q;
  logic wr_sec, wr_frac, wr_stage, wr_lo;

  assign wr_sec   = csr_we && (csr_addr == ADR_SEC);
  assign wr_frac  = csr_we && (csr_addr == ADR_FRAC);
  assign wr_stage = csr_we && (csr_addr == ADR_PER_MID);
  assign wr_lo    = csr_we && (csr_addr == ADR_PER_LO);

  clk_period_regs #(.QUAD_W(QUAD_W)) u_period (
    .clk(clk), .rst_n(rst_n), .wr_stage(wr_stage), .wr_lo(wr_lo),
    .wdata(csr_wdata), .stage_q(stage_q), .act_mid_q(act_mid_q), .lo_q(lo_q)
  );

  clk_accum #(.QUAD_W(QUAD_W), .HIDDEN_W(HIDDEN_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wr_sec(wr_sec),
    .wr_frac(wr_frac), .wdata(csr_wdata), .inc_mid(act_mid_q),
    .inc_lo(lo_q), .acc_q(acc_q)
  );

  clk_strobe_latch #(.QUAD_W(QUAD_W), .N_WORDS(2)) u_snap (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .snap_in(acc_q[ACC_W-1 -: 2*QUAD_W]), .snap_q(snap_q)
  );

  always_comb begin
    unique case (csr_addr)
      ADR_SEC:      csr_rdata = acc_q[ACC_W-1 -: QUAD_W];
      ADR_FRAC:     csr_rdata = acc_q[ACC_W-QUAD_W-1 -: QUAD_W];
      ADR_PER_MID:  csr_rdata = stage_q;
      ADR_PER_LO:   csr_rdata = lo_q;
      ADR_SNAP_SEC: csr_rdata = snap_q[2*QUAD_W-1 -: QUAD_W];
      ADR_SNAP_FRC: csr_rdata = snap_q[QUAD_W-1:0];
      default:      csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sync_clock_unit_chk.sv
module sync_clock_unit_chk #(
  parameter int QUAD_W   = 32,
  parameter int HIDDEN_W = 32,
  localparam int ACC_W   = 2*QUAD_W + HIDDEN_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                strobe,
  input logic [2:0]          csr_addr,
  input logic                csr_we,
  input logic [QUAD_W-1:0]   csr_wdata,
  input logic [ACC_W-1:0]    acc_q,
  input logic [QUAD_W-1:0]   stage_q,
  input logic [QUAD_W-1:0]   act_mid_q,
  input logic [QUAD_W-1:0]   lo_q,
  input logic [2*QUAD_W-1:0] snap_q
);
  logic val_wr;
  logic [ACC_W-1:0] exp_inc;
  assign val_wr  = csr_we && (csr_addr == 3'd0 || csr_addr == 3'd1);
  assign exp_inc = (ACC_W'(act_mid_q) << HIDDEN_W) +
                   ((ACC_W'(lo_q) << HIDDEN_W) >> QUAD_W);

  assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !val_wr) |=> (acc_q == $past(acc_q) + $past(exp_inc)));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !val_wr) |=> $stable(acc_q));
  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd2) |=> ($stable(act_mid_q) && stage_q == $past(csr_wdata)));
  assert_lo_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd3) |=> (act_mid_q == $past(stage_q) && lo_q == $past(csr_wdata)));
  assert_sec_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd0) |=> (acc_q[ACC_W-1 -: QUAD_W] == $past(csr_wdata)
                                      && acc_q[HIDDEN_W-1:0] == '0));
  assert_frac_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd1) |=> (acc_q[ACC_W-QUAD_W-1 -: QUAD_W] == $past(csr_wdata)
                                      && $stable(acc_q[ACC_W-1 -: QUAD_W])));
  assert_snap_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (snap_q == $past(acc_q[ACC_W-1 -: 2*QUAD_W])));
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(snap_q));
endmodule

bind sync_clock_unit sync_clock_unit_chk #(.QUAD_W(QUAD_W), .HIDDEN_W(HIDDEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .strobe(strobe),
  .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .acc_q(acc_q), .stage_q(stage_q), .act_mid_q(act_mid_q), .lo_q(lo_q),
  .snap_q(snap_q)
);

// File: tb/sync_clock_unit_tb.sv
`timescale 1ns/1ps
module sync_clock_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, strobe = 1'b0, csr_we = 1'b0;
  logic [2:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  int errors = 0, checks = 0;

  // arithmetic model
  logic [95:0] m_acc = '0;
  logic [31:0] m_stage = '0, m_mid = '0, m_lo = '0, m_ssec = '0, m_sfrc = '0;

  always #4 clk = ~clk;

  sync_clock_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .strobe(strobe),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata)
  );

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return m_acc[95:64];
      1: return m_acc[63:32];
      2: return m_stage;
      3: return m_lo;
      4: return m_ssec;
      5: return m_sfrc;
      default: return 32'h0;
    endcase
  endfunction

  // one clock cycle with the given stimulus; model follows the requirements
  task automatic step(input logic we, input int a, input logic [31:0] d,
                      input logic tk, input logic sb);
    logic [95:0] nxt;
    @(negedge clk);
    csr_we = we; csr_addr = 3'(a); csr_wdata = d; tick_en = tk; strobe = sb;
    @(posedge clk);
    nxt = m_acc;
    if (sb) begin m_ssec = m_acc[95:64]; m_sfrc = m_acc[63:32]; end
    if (we && a == 0)      nxt = {d, m_acc[63:32], 32'h0};
    else if (we && a == 1) nxt = {m_acc[95:64], d, 32'h0};
    else if (tk)           nxt = m_acc + {32'h0, m_mid, m_lo};
    if (we && a == 3) begin m_lo = d; m_mid = m_stage; end
    if (we && a == 2) m_stage = d;
    m_acc = nxt;
    @(negedge clk);
    csr_we = 1'b0; tick_en = 1'b0; strobe = 1'b0; csr_wdata = '0;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      csr_addr = 3'(a);
      #0.4;
      checks++;
      if (csr_rdata !== exp_rd(a)) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, csr_rdata, exp_rd(a));
      end
    end
  endtask

  task automatic set_period(input logic [31:0] mid, input logic [31:0] lo);
    step(1'b1, 2, mid, 1'b0, 1'b0);
    step(1'b1, 3, lo, 1'b0, 1'b0);
  endtask

  initial begin
    #(8.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lo_set [4];
    lo_set[0] = 32'h0; lo_set[1] = 32'h4000_0000;
    lo_set[2] = 32'h8000_0000; lo_set[3] = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R4: staged middle word does not move the clock
    step(1'b1, 2, 32'h5, 1'b0, 1'b0);
    check_all("R4 staged readback");
    repeat (3) step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R4 no effect before commit");

    // R5: commit then ticks
    step(1'b1, 3, 32'h8000_0000, 1'b0, 1'b0);
    check_all("R5 commit");
    repeat (3) step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R2 ticks after commit");

    // R2 sweep over period patterns and tick counts
    for (int mv = 0; mv < 4; mv++) begin
      for (int li = 0; li < 4; li++) begin
        set_period(32'(mv * 32'h3000_0001), lo_set[li]);
        step(1'b1, 1, 32'h0, 1'b0, 1'b0);
        step(1'b1, 0, 32'(mv + li), 1'b0, 1'b0);
        for (int k = 0; k < 5; k++) begin
          step(1'b0, 0, 0, 1'b1, 1'b0);
          check_all("R2 sweep");
        end
      end
    end

    // R6: hidden bits cleared by a fraction write
    set_period(32'h0, 32'h8000_0000);
    step(1'b0, 0, 0, 1'b1, 1'b0);
    step(1'b1, 1, 32'h5, 1'b0, 1'b0);
    step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R6 hidden cleared");
    // R6: value writes beat a same-cycle tick
    set_period(32'h10, 32'h0);
    step(1'b1, 1, 32'hABCD_0000, 1'b1, 1'b0);
    check_all("R6 frac write vs tick");
    step(1'b1, 0, 32'h1234_5678, 1'b1, 1'b0);
    check_all("R6 sec write vs tick");

    // R5: commit in the same cycle as a tick uses the old increment
    step(1'b1, 2, 32'h100, 1'b0, 1'b0);
    step(1'b1, 3, 32'h0, 1'b1, 1'b0);
    check_all("R5 commit vs tick");
    step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R5 new increment");

    // R7: strobe with tick and with a write captures pre-edge time
    step(1'b0, 0, 0, 1'b1, 1'b1);
    check_all("R7 strobe vs tick");
    repeat (2) step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R7 snapshot holds");
    step(1'b1, 0, 32'h7777_0000, 1'b0, 1'b1);
    check_all("R7 strobe vs write");
    step(1'b1, 4, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step(1'b1, 5, 32'hDEAD_BEEF, 1'b0, 1'b0);
    check_all("R7 snapshot read-only");

    // R8: unused addresses
    step(1'b1, 6, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step(1'b1, 7, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check_all("R8 unused addresses");

    // R3: wrap at 2^96
    set_period(32'h1, 32'h0);
    step(1'b1, 1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step(1'b1, 0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R3 wrap");
    set_period(32'h0, 32'hFFFF_FFFF);
    step(1'b1, 1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step(1'b1, 0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    repeat (2) step(1'b0, 0, 0, 1'b1, 1'b0);
    check_all("R3 wrap through hidden bits");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule